// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation and function fields of a 32-bit instruction word into the control levels that steer a single-cycle datapath. It is purely combinational. It takes the 6-bit opcode and the 6-bit function field. It produces these outputs:

- write-destination select
- register write enable
- ALU second-operand select
- immediate extension mode
- memory write and memory read enables
- write-back source select
- branch-on-equal and jump flags
- a 3-bit ALU operation code

The ALU operation is resolved in two levels. The opcode decoder picks an operation class. For register-register instructions, a second decoder then resolves the class from the function field. Every output that an instruction does not use is driven to 0. An opcode or function code that is not recognised produces no write, no branch and no jump.

Top module: `ctl_decoder`

## Requirements
- R1: Opcode 000000 with function 100000 (add) gives reg_we=1, alu_op=000, dst_sel_rt=0, alu_b_imm=0, and every other output 0.
- R2: Opcode 000000 with function 100010, 100100, 100101 or 101010 gives alu_op 001 (sub), 010 (and), 011 (or) or 100 (slt) respectively, with the same control levels as R1.
- R3: Opcode 000000 with any other function code drives every output to 0, including alu_op.
- R4: Opcode 001101 (or-immediate) gives dst_sel_rt=1, reg_we=1, alu_b_imm=1, ext_signed=0, alu_op=011, and every other output 0.
- R5: Opcode 100011 (load word) gives dst_sel_rt=1, reg_we=1, alu_b_imm=1, ext_signed=1, wb_from_mem=1, mem_re=1, mem_we=0, alu_op=000, branch and jump 0.
- R6: Opcode 101011 (store word) gives mem_we=1, ext_signed=1, alu_b_imm=1, alu_op=000, and reg_we, mem_re, dst_sel_rt, wb_from_mem, br_eq and jmp all 0.
- R7: Opcode 000100 (branch if equal) gives br_eq=1, alu_op=001, and every other output 0.
- R8: Opcode 000010 (jump) gives jmp=1, alu_op=000, and every other output 0.
- R9: Any other opcode drives every output to 0, regardless of the function field.
- R10: mem_re and mem_we are never 1 together, and at most one of reg_we, mem_we, br_eq and jmp is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Operation field of the instruction |
| funct | input | 6 | Function field, used only for register-register operations |
| dst_sel_rt | output | 1 | 1 selects the rt field as the write register, 0 selects rd |
| reg_we | output | 1 | Register file write enable |
| alu_b_imm | output | 1 | 1 feeds the extended immediate to the ALU second operand |
| ext_signed | output | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| mem_we | output | 1 | Data memory write enable |
| mem_re | output | 1 | Data memory read enable |
| wb_from_mem | output | 1 | 1 writes memory data back, 0 writes the ALU result |
| br_eq | output | 1 | Branch-on-equal instruction |
| jmp | output | 1 | Unconditional jump instruction |
| alu_op | output | 3 | ALU operation: 000 add, 001 sub, 010 and, 011 or, 100 slt |

## Verification
The opcode decode and the function-field decode act on the same word in the same cycle. A function code that is meaningful for register-register operations must never change the outcome of an immediate, memory, branch or jump instruction. It must also never revive a write when the opcode is unknown. Random stimulus pairs every opcode, including unlisted ones, with both valid and arbitrary function codes. Each combination is judged against a specification table in the bench. Directed cases put a valid function code on non-register opcodes and an invalid one on the register-register opcode.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 3;

    typedef logic [OP_W-1:0] opcode_t;
    typedef logic [FN_W-1:0] funct_t;

    localparam opcode_t OPC_REG  = 6'b000000;
    localparam opcode_t OPC_ORI  = 6'b001101;
    localparam opcode_t OPC_LOAD = 6'b100011;
    localparam opcode_t OPC_STOR = 6'b101011;
    localparam opcode_t OPC_BEQ  = 6'b000100;
    localparam opcode_t OPC_JMP  = 6'b000010;

    localparam funct_t FN_ADD = 6'b100000;
    localparam funct_t FN_SUB = 6'b100010;
    localparam funct_t FN_AND = 6'b100100;
    localparam funct_t FN_OR  = 6'b100101;
    localparam funct_t FN_SLT = 6'b101010;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_AND = 3'b010,
        ALU_OR  = 3'b011,
        ALU_SLT = 3'b100
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'd0,
        CLS_SUB   = 2'd1,
        CLS_OR    = 2'd2,
        CLS_FUNCT = 2'd3
    } alu_cls_e;

    typedef struct packed {
        logic dst_rt;
        logic reg_we;
        logic b_imm;
        logic ext_sgn;
        logic mem_we;
        logic mem_re;
        logic wb_mem;
        logic br;
        logic jmp;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  opcode_t  opcode,
    output ctl_t     ctl,
    output alu_cls_e cls,
    output logic     is_reg
);

    always_comb begin
        ctl    = CTL_IDLE;
        cls    = CLS_ADD;
        is_reg = 1'b0;
        unique case (opcode)
            OPC_REG: begin
                ctl.reg_we = 1'b1;
                cls        = CLS_FUNCT;
                is_reg     = 1'b1;
            end
            OPC_ORI: begin
                ctl.dst_rt = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.b_imm  = 1'b1;
                cls        = CLS_OR;
            end
            OPC_LOAD: begin
                ctl.dst_rt  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.b_imm   = 1'b1;
                ctl.ext_sgn = 1'b1;
                ctl.mem_re  = 1'b1;
                ctl.wb_mem  = 1'b1;
            end
            OPC_STOR: begin
                ctl.b_imm   = 1'b1;
                ctl.ext_sgn = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.br = 1'b1;
                cls    = CLS_SUB;
            end
            OPC_JMP: begin
                ctl.jmp = 1'b1;
            end
            default: begin
                ctl = CTL_IDLE;
            end
        endcase
    end

    // R10: memory read and write come from disjoint opcode arms
    always_comb begin
        p_mem_excl_r10: assert (!(ctl.mem_re && ctl.mem_we))
            else $error("main decoder raised memory read and write together");
    end

endmodule

// File: rtl/ctl_alu_dec.sv
module ctl_alu_dec
    import ctl_pkg::*;
(
    input  alu_cls_e cls,
    input  funct_t   funct,
    output alu_op_e  op,
    output logic     fn_ok
);

    always_comb begin
        op    = ALU_ADD;
        fn_ok = 1'b1;
        unique case (cls)
            CLS_ADD: op = ALU_ADD;
            CLS_SUB: op = ALU_SUB;
            CLS_OR:  op = ALU_OR;
            CLS_FUNCT: begin
                unique case (funct)
                    FN_ADD:  op = ALU_ADD;
                    FN_SUB:  op = ALU_SUB;
                    FN_AND:  op = ALU_AND;
                    FN_OR:   op = ALU_OR;
                    FN_SLT:  op = ALU_SLT;
                    default: begin
                        op    = ALU_ADD;
                        fn_ok = 1'b0;
                    end
                endcase
            end
            default: op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/ctl_decoder.sv
module ctl_decoder
    import ctl_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output logic       dst_sel_rt,
    output logic       reg_we,
    output logic       alu_b_imm,
    output logic       ext_signed,
    output logic       mem_we,
    output logic       mem_re,
    output logic       wb_from_mem,
    output logic       br_eq,
    output logic       jmp,
    output logic [2:0] alu_op
);

    ctl_t     main_ctl;
    ctl_t     fin_ctl;
    alu_cls_e cls;
    logic     is_reg;
    alu_op_e  raw_op;
    logic     fn_ok;
    logic     drop;

    ctl_main_dec u_main (
        .opcode (opcode),
        .ctl    (main_ctl),
        .cls    (cls),
        .is_reg (is_reg)
    );

    ctl_alu_dec u_alu (
        .cls   (cls),
        .funct (funct),
        .op    (raw_op),
        .fn_ok (fn_ok)
    );

    // An unrecognised function code on a register-register opcode squashes everything
    assign drop    = is_reg && !fn_ok;
    assign fin_ctl = drop ? CTL_IDLE : main_ctl;

    assign dst_sel_rt  = fin_ctl.dst_rt;
    assign reg_we      = fin_ctl.reg_we;
    assign alu_b_imm   = fin_ctl.b_imm;
    assign ext_signed  = fin_ctl.ext_sgn;
    assign mem_we      = fin_ctl.mem_we;
    assign mem_re      = fin_ctl.mem_re;
    assign wb_from_mem = fin_ctl.wb_mem;
    assign br_eq       = fin_ctl.br;
    assign jmp         = fin_ctl.jmp;
    assign alu_op      = drop ? 3'b000 : 3'(raw_op);

    always_comb begin
        // R10: only one kind of state change per instruction
        p_one_effect_r10: assert ($onehot0({reg_we, mem_we, br_eq, jmp}))
            else $error("more than one state-changing control raised");
        // R7: a branch compares by subtraction
        p_branch_sub_r7: assert (!br_eq || alu_op == 3'b001)
            else $error("branch without subtract");
        // R5 and R6: memory addresses are formed by addition
        p_mem_add_r5: assert (!(mem_we || mem_re) || alu_op == 3'b000)
            else $error("memory access without add");
        // R3: a rejected function code leaves no write behind
        p_bad_fn_r3: assert (fn_ok || !reg_we)
            else $error("register write on an unknown function code");
        // R4: immediate operand outside memory access means or-immediate
        p_imm_or_r4: assert (!(alu_b_imm && !mem_we && !mem_re) || alu_op == 3'b011)
            else $error("immediate operand with wrong ALU operation");
    end

endmodule

// File: tb/ctl_decoder_test.sv
module ctl_decoder_test;

    logic       clk = 1'b0;
    logic [5:0] opcode;
    logic [5:0] funct;
    logic       dst_sel_rt, reg_we, alu_b_imm, ext_signed;
    logic       mem_we, mem_re, wb_from_mem, br_eq, jmp;
    logic [2:0] alu_op;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ctl_decoder uut (
        .opcode      (opcode),
        .funct       (funct),
        .dst_sel_rt  (dst_sel_rt),
        .reg_we      (reg_we),
        .alu_b_imm   (alu_b_imm),
        .ext_signed  (ext_signed),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .wb_from_mem (wb_from_mem),
        .br_eq       (br_eq),
        .jmp         (jmp),
        .alu_op      (alu_op)
    );

    // Packed order: dst, we, bimm, ext, mwe, mre, wbm, br, jmp, alu[2:0]
    function automatic logic [11:0] spec(input logic [5:0] op, input logic [5:0] fn);
        logic [2:0] a;
        case (op)
            6'b000000: begin
                case (fn)
                    6'b100000: a = 3'b000;
                    6'b100010: a = 3'b001;
                    6'b100100: a = 3'b010;
                    6'b100101: a = 3'b011;
                    6'b101010: a = 3'b100;
                    default:   return 12'h000;
                endcase
                return {9'b010000000, a};
            end
            6'b001101: return {9'b111000000, 3'b011};
            6'b100011: return {9'b111101100, 3'b000};
            6'b101011: return {9'b001110000, 3'b000};
            6'b000100: return {9'b000000010, 3'b001};
            6'b000010: return {9'b000000001, 3'b000};
            default:   return 12'h000;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'b000000: begin
                if (fn == 6'b100000) return "R1";
                if (fn == 6'b100010 || fn == 6'b100100 || fn == 6'b100101 || fn == 6'b101010)
                    return "R2";
                return "R3";
            end
            6'b001101: return "R4";
            6'b100011: return "R5";
            6'b101011: return "R6";
            6'b000100: return "R7";
            6'b000010: return "R8";
            default:   return "R9";
        endcase
    endfunction

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input string tag);
        logic [11:0] got, exp;
        @(posedge clk);
        opcode = op;
        funct  = fn;
        @(negedge clk);
        got = {dst_sel_rt, reg_we, alu_b_imm, ext_signed, mem_we, mem_re,
               wb_from_mem, br_eq, jmp, alu_op};
        exp = spec(op, fn);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s op=%b fn=%b actual=%b expected=%b", tag, op, fn, got, exp);
        end
        // R10 at the ports
        n_checks++;
        if ((mem_re && mem_we) || ($countones({reg_we, mem_we, br_eq, jmp}) > 1)) begin
            n_fails++;
            $display("FAIL R10 op=%b fn=%b actual=%b expected=exclusive", op, fn, got);
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [5:0] known_op [6];
        logic [5:0] known_fn [5];
        int unsigned seed_val;
        known_op = '{6'b000000, 6'b001101, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
        known_fn = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
        seed_val = $urandom(32'h5EED);
        opcode = 6'b111111;
        funct  = 6'b000000;

        // idle state: unlisted opcode gives all-zero controls (R9)
        apply(6'b111111, 6'b000000, "R9");
        apply(6'b000000, 6'b100000, "R1");
        apply(6'b000000, 6'b100010, "R2");
        apply(6'b000000, 6'b100100, "R2");
        apply(6'b000000, 6'b100101, "R2");
        apply(6'b000000, 6'b101010, "R2");
        apply(6'b000000, 6'b000000, "R3");
        apply(6'b000000, 6'b100001, "R3");
        apply(6'b001101, 6'b100010, "R4");
        apply(6'b100011, 6'b101010, "R5");
        apply(6'b101011, 6'b100101, "R6");
        apply(6'b000100, 6'b100000, "R7");
        apply(6'b000010, 6'b100100, "R8");
        apply(6'b000011, 6'b100000, "R9");
        apply(6'b100000, 6'b100101, "R9");

        for (int i = 0; i < 3000; i++) begin
            int unsigned r;
            logic [5:0] op, fn;
            r  = $urandom;
            op = (r % 8 < 6) ? known_op[r % 8] : 6'($urandom);
            fn = ($urandom % 2 == 0) ? known_fn[$urandom % 5] : 6'($urandom);
            apply(op, fn, req_of(op, fn));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule